// File: doc/BRIEF.md
# Multi-Cycle Integer Divide and Remainder Unit

This block computes quotients and remainders for a 64-bit integer core. It handles signed and unsigned division and remainder on full-width operands, and the 32-bit word forms that narrow the operands and widen the result back to 64 bits. The caller pulses `start` for one cycle with two operands and a three-bit operation code while `busy` is low. Some time later, `done` pulses for one cycle and `result` carries the answer.

A zero divisor, or a full-width signed divide of the most negative value by -1, is settled in the cycle the request is accepted. These cases never trap. Every other request runs through a restoring shift-subtract loop that produces one quotient bit per cycle on the operand magnitudes, followed by one cycle that fixes the signs. A request that arrives while a division is in flight is dropped.

Top module: `divUnit`

## Requirements
- R1: The operation code uses bit 0 for unsigned (1) or signed (0), bit 1 for remainder (1) or quotient (0), and bit 2 for the word form (1) or the full-width form (0).
- R2: A quotient with a zero divisor, signed or unsigned, is all ones. This applies after narrowing, so for the word forms only the low 32 bits of the divisor are looked at.
- R3: A remainder with a zero divisor returns the dividend unchanged. For the word forms this is the sign-extended low 32 bits of the dividend.
- R4: For a full-width signed divide of 0x8000000000000000 by -1, the quotient equals the dividend and the remainder is zero.
- R5: A signed quotient truncates toward zero and is negative when the operand signs differ. A signed remainder takes the sign of the dividend, and magnitude(remainder) < magnitude(divisor).
- R6: Unsigned forms treat both operands as 64-bit unsigned numbers.
- R7: Word forms use only the low 32 bits of each operand. These bits are sign-extended for signed forms and zero-extended for unsigned forms. The result is the low 32 bits of the 64-bit answer, sign-extended.
- R8: A zero-divisor or full-width overflow request raises `done` in the cycle right after its accepting edge, and `busy` stays low. Any other request holds `busy` high from the accepting edge on and raises `done` 65 clock edges after that edge.
- R9: `start` while `busy` is high is ignored. The operation in flight keeps its operands and produces exactly one `done`.
- R10: `busy` and `done` are never high together. `result` changes only when `done` is high and holds its value otherwise.
- R11: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken when busy is low |
| opCode | input | 3 | Operation code {word, remainder, unsigned} |
| dividend | input | 64 | First operand |
| divisor | input | 64 | Second operand |
| busy | output | 1 | A long division is in progress |
| done | output | 1 | One-cycle strobe: result is valid |
| result | output | 64 | Quotient or remainder |

## Verification
The hardest case to reach is a word-form request whose upper operand halves contain junk. Such a request can look like a zero divisor or the overflow pattern in one width but not in the other. The stimulus places a zero low half under a nonzero upper half, and a narrowed 0x80000000 over -1. It also sends random operands in which the divisor is sometimes forced to zero and the dividend to the most negative value. To show that a request arriving mid-division is really dropped, extra starts with different operands are driven during a long operation. The monitor then requires exactly one `done` carrying the first request's answer.

// File: rtl/divPkg.sv
package divPkg;
  localparam int OP_UNS_BIT  = 0;
  localparam int OP_REM_BIT  = 1;
  localparam int OP_WORD_BIT = 2;
  localparam int OP_W        = 3;

  typedef struct packed {
    logic loadQuick;
    logic loadRun;
    logic step;
    logic finish;
  } divCtrlT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divStateT;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    quickCase,
  output divCtrlT ctrl,
  output logic    busy,
  output logic    done
);
  localparam int CNT_W = $clog2(XLEN);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(XLEN - 1);

  divStateT state;
  logic [CNT_W-1:0] stepCnt;
  logic doneR;
  logic accept;

  always_comb begin
    accept = start && (state == ST_IDLE);
    ctrl.loadQuick = accept && quickCase;
    ctrl.loadRun   = accept && !quickCase;
    ctrl.step      = (state == ST_RUN);
    ctrl.finish    = (state == ST_FIX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= ctrl.loadQuick || ctrl.finish;
      unique case (state)
        ST_IDLE: begin
          if (ctrl.loadRun) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneR;
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  divCtrlT         ctrl,
  input  logic [OP_W-1:0] opCode,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            quickCase,
  output logic [XLEN-1:0] result
);
  localparam int EXT_W = XLEN - WLEN;
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  function automatic logic [XLEN-1:0] narrowOp(input logic [XLEN-1:0] v, input logic sgn);
    return {{EXT_W{sgn & v[WLEN-1]}}, v[WLEN-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] wordFix(input logic [XLEN-1:0] v, input logic isW);
    return isW ? {{EXT_W{v[WLEN-1]}}, v[WLEN-1:0]} : v;
  endfunction

  // operand preparation
  logic isUns, isRemIn, isWordIn;
  logic [XLEN-1:0] opA, opB, magA, magB;
  logic zeroDiv, ovfl;
  logic [XLEN-1:0] quickRaw;

  always_comb begin
    isUns    = opCode[OP_UNS_BIT];
    isRemIn  = opCode[OP_REM_BIT];
    isWordIn = opCode[OP_WORD_BIT];
    opA = isWordIn ? narrowOp(dividend, !isUns) : dividend;
    opB = isWordIn ? narrowOp(divisor, !isUns) : divisor;
    magA = (!isUns && opA[XLEN-1]) ? (~opA + 1'b1) : opA;
    magB = (!isUns && opB[XLEN-1]) ? (~opB + 1'b1) : opB;
    zeroDiv = (opB == '0);
    ovfl    = !isUns && !isWordIn && (opA == MOST_NEG) && (opB == '1);
    quickCase = zeroDiv || ovfl;
    if (zeroDiv) quickRaw = isRemIn ? opA : '1;
    else         quickRaw = isRemIn ? '0 : opA;
  end

  // iteration state
  logic [XLEN-1:0] quoR, remR, divR;
  logic negQ, negR, isRemR, isWordR;
  logic [XLEN:0] shifted, trial;
  logic [XLEN-1:0] qFinal, rFinal, longRaw;
  logic [XLEN-1:0] resultR;

  always_comb begin
    shifted = {remR, quoR[XLEN-1]};
    trial   = shifted - {1'b0, divR};
    qFinal  = negQ ? (~quoR + 1'b1) : quoR;
    rFinal  = negR ? (~remR + 1'b1) : remR;
    longRaw = isRemR ? rFinal : qFinal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoR    <= '0;
      remR    <= '0;
      divR    <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
      isRemR  <= 1'b0;
      isWordR <= 1'b0;
    end else if (ctrl.loadRun) begin
      quoR    <= magA;
      remR    <= '0;
      divR    <= magB;
      negQ    <= !isUns && (opA[XLEN-1] ^ opB[XLEN-1]);
      negR    <= !isUns && opA[XLEN-1];
      isRemR  <= isRemIn;
      isWordR <= isWordIn;
    end else if (ctrl.step) begin
      if (!trial[XLEN]) begin
        remR <= trial[XLEN-1:0];
        quoR <= {quoR[XLEN-2:0], 1'b1};
      end else begin
        remR <= shifted[XLEN-1:0];
        quoR <= {quoR[XLEN-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               resultR <= '0;
    else if (ctrl.loadQuick) resultR <= wordFix(quickRaw, isWordIn);
    else if (ctrl.finish)    resultR <= wordFix(longRaw, isWordR);
  end

  assign result = resultR;
endmodule

// File: rtl/divUnit.sv
module divUnit
  import divPkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2:0]      opCode,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  divCtrlT ctrl;
  logic quickCase;

  divCtrl #(.XLEN(XLEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .quickCase(quickCase),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  divDatapath #(.XLEN(XLEN), .WLEN(WLEN)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opCode(opCode),
    .dividend(dividend), .divisor(divisor),
    .quickCase(quickCase), .result(result)
  );
endmodule

// File: rtl/divUnitChk.sv
module divUnitChk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [2:0]      opCode,
  input logic [XLEN-1:0] dividend,
  input logic [XLEN-1:0] divisor,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result
);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  assert_zero_quot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !opCode[1] && !opCode[2] && divisor == '0)
      |=> (done && !busy && result == '1));

  assert_zero_rem_R3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opCode[1] && !opCode[2] && divisor == '0)
      |=> (done && result == $past(dividend)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opCode == 3'b000 && dividend == MOST_NEG && divisor == '1)
      |=> (done && result == MOST_NEG));

  assert_ovfl_rem_R4: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opCode == 3'b010 && dividend == MOST_NEG && divisor == '1)
      |=> (done && result == '0));
endmodule

bind divUnit divUnitChk #(.XLEN(XLEN)) i_divUnitChk (.*);

// File: tb/test_divUnit.sv
module test_divUnit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int RUN_LAT = XLEN + 1;
  localparam logic [63:0] MNEG = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] opCode = '0;
  logic [63:0] dividend = '0, divisor = '0;
  logic busy, done;
  logic [63:0] result;

  divUnit i_divUnit (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [63:0] expRes;
    int          expCyc;
    string       tag;
  } itemT;

  itemT sbq[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int holdErrs = 0;
  logic [63:0] lastRes = '0;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: opCode bit0 unsigned, bit1 remainder, bit2 word (R1)
  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b, output logic quick);
    logic uns, rem, w;
    logic [63:0] x, y, q, r, res;
    longint sx, sy;
    uns = op[0]; rem = op[1]; w = op[2];
    x = w ? (uns ? {32'b0, a[31:0]} : {{32{a[31]}}, a[31:0]}) : a;
    y = w ? (uns ? {32'b0, b[31:0]} : {{32{b[31]}}, b[31:0]}) : b;
    quick = 1'b0;
    if (y == 0) begin
      q = '1; r = x; quick = 1'b1;
    end else if (!uns && !w && x == MNEG && y == '1) begin
      q = x; r = '0; quick = 1'b1;
    end else if (uns) begin
      q = x / y; r = x % y;
    end else begin
      sx = x; sy = y;
      q = sx / sy; r = sx % sy;
    end
    res = rem ? r : q;
    if (w) res = {{32{res[31]}}, res[31:0]};
    return res;
  endfunction

  task automatic doOp(input string tag, input logic [2:0] op,
                      input logic [63:0] a, input logic [63:0] b);
    itemT it;
    logic quick;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; opCode = op; dividend = a; divisor = b;
    it.expRes = model(op, a, b, quick);
    it.expCyc = cyc + 1 + (quick ? 0 : RUN_LAT);
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        nChecks++;
        if (busy) begin
          nFails++;
          $display("FAIL R10 busy with done actual=1 expected=0");
        end
        if (sbq.size() == 0) begin
          nFails++;
          nChecks++;
          $display("FAIL R9 unexpected done actual=%h expected=none", result);
        end else begin
          itemT it;
          it = sbq.pop_front();
          chk({it.tag, " result"}, result, it.expRes);
          chk({it.tag, " R8 latency"}, 64'(cyc), 64'(it.expCyc));
        end
        lastRes = result;
      end else if (result !== lastRes) begin
        holdErrs++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy", 64'(busy), 64'd0);
    chk("R11 done", 64'(done), 64'd0);
    chk("R11 result", result, 64'd0);
    rstN = 1'b1;

    // R6 unsigned, R5 signed
    doOp("R6 divu", 3'b001, 64'd100, 64'd7);
    doOp("R6 remu", 3'b011, 64'd100, 64'd7);
    doOp("R6 divu max", 3'b001, '1, 64'd1);
    doOp("R6 remu big", 3'b011, '1, 64'hFFFF_FFFF_FFFF_FFFE);
    doOp("R5 div neg/pos", 3'b000, -64'sd100, 64'd7);
    doOp("R5 rem neg/pos", 3'b010, -64'sd100, 64'd7);
    doOp("R5 div pos/neg", 3'b000, 64'd100, -64'sd7);
    doOp("R5 rem pos/neg", 3'b010, 64'd100, -64'sd7);
    doOp("R5 div neg/neg", 3'b000, -64'sd100, -64'sd7);
    doOp("R5 div minneg/2", 3'b000, MNEG, 64'd2);
    // R2 / R3 zero divisor
    doOp("R2 div zero", 3'b000, 64'd55, 64'd0);
    doOp("R2 divu zero", 3'b001, 64'd55, 64'd0);
    doOp("R3 rem zero", 3'b010, -64'sd9, 64'd0);
    doOp("R3 remu zero", 3'b011, 64'hDEAD_BEEF_0000_1234, 64'd0);
    // R4 overflow
    doOp("R4 div ovfl", 3'b000, MNEG, '1);
    doOp("R4 rem ovfl", 3'b010, MNEG, '1);
    // R7 word forms
    doOp("R7 divuw junk", 3'b101, 64'hFFFF_FFFF_0000_0064, 64'h1234_5678_0000_0007);
    doOp("R7 divw neg", 3'b100, 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_0000_0007);
    doOp("R7 remw", 3'b110, 64'h0000_0000_FFFF_FF9C, 64'd7);
    doOp("R7 divw ovfl", 3'b100, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
    doOp("R7 remw ovfl", 3'b110, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
    doOp("R7 R2 divuw zero low", 3'b101, 64'd77, 64'h0000_0001_0000_0000);
    doOp("R7 R3 remw zero low", 3'b110, 64'h1234_5678_8765_4321, 64'hFFFF_0000_0000_0000);
    doOp("R7 remuw", 3'b111, 64'h0000_0000_FFFF_FFFF, 64'd10);

    // R9: starts while busy are ignored
    doOp("R9 base", 3'b001, 64'd1000, 64'd3);
    for (int i = 0; i < 10; i++) begin
      start = 1'b1; opCode = 3'b000; dividend = 64'd5 + 64'(i); divisor = 64'd0;
      @(negedge clk);
    end
    start = 1'b0;

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b;
      logic [2:0] op;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      op = 3'($urandom);
      if (i % 5 == 1) b = '0;
      if (i % 7 == 2) begin a = MNEG; b = '1; end
      if (i % 4 == 3) b = b >> ($urandom % 60);
      doOp("R5 R6 R7 random", op, a, b);
    end

    @(negedge clk);
    while (busy || sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9 pending items", 64'(sbq.size()), 64'd0);
    chk("R10 result held", 64'(holdErrs), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule